// File: doc/BRIEF.md
# Serial Flash Status Byte Output

This block builds the 8-bit status byte of a serial flash device and returns it on the serial data output during a status read. The byte combines a ready flag taken live from the busy requests of the internal operations, a sticky flag that holds the outcome of the last page-to-buffer compare, and a fixed density code. The host selects the device, clocks in the status-read opcode MSB first, and then clocks the status byte out MSB first.

The host can poll for completion. It parks the serial clock low once the ready bit has been driven. While it waits, the output follows the live ready state and rises from 0 to 1 as soon as the last busy request clears. If clocking resumes, the remaining bits follow in order and the byte then repeats. The serial pins are oversampled by the system clock. They are assumed to be synchronised to it upstream.

Top module: `flash_stat_out`

## Requirements
- R1: Status bit 7 is the ready flag. It is 1 when no bit of `busy_src` is set and 0 when any bit is set. Each of the eight busy sources alone forces it to 0.
- R2: Status bit 6 takes the value of `cmp_mismatch` in the cycle where `cmp_done` is high. The value 0 means the page matched the buffer and 1 means a bit differed.
- R3: Status bit 6 is sticky. It changes only on `cmp_done`, and `cmp_mismatch` has no effect at other times.
- R4: Status bits 5 to 2 carry the `DENSITY` code, which is 4'b0111 by default. Bit 5 holds the code's MSB.
- R5: Status bits 1 and 0 always read 0.
- R6: With `cs_n` low, `si` is sampled on each rising `sck` edge, MSB first. When the 8 bits equal `OPCODE` (default 8'hD7), the falling `sck` edge after the 8th rise drives status bit 7 on `so`. Each later falling edge drives the next lower bit. `so` is updated one system clock after the falling edge is seen.
- R7: While status bit 7 is on `so` and `sck` stays low, `so` follows the live ready flag, one system clock behind `busy_src`, in both directions.
- R8: When clocking resumes after polling, the next falling edges give bits 6 down to 0. The falling edge after bit 0 drives bit 7 again, and the byte repeats.
- R9: `so_oe` is 0 while the opcode is being shifted in. It is 0 one system clock after `cs_n` goes high.
- R10: If the opcode does not match, `so_oe` stays 0 for the rest of that selection.
- R11: Synchronous active-high `rst` clears `so_oe` and the compare flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, idle low |
| si | input | 1 | Serial data input |
| busy_src | input | N_SRC | One busy request per internal operation |
| cmp_done | input | 1 | One-cycle pulse when a compare completes |
| cmp_mismatch | input | 1 | Compare outcome, valid with cmp_done |
| so | output | 1 | Serial data output (registered) |
| so_oe | output | 1 | Output enable for so; 0 means high impedance |

## Verification
A wrong bit pointer shows at the ports on the next falling `sck` edge. It appears as a density or zero bit in the wrong place, or as a byte that does not repeat at bit 7. A stale ready value during polling appears one system clock after `busy_src` changes. A compare flag that is not sticky appears only on the next status read, so the stimulus table flips `cmp_mismatch` after every compare pulse. If the select logic fails to reset, `so_oe` stays high one clock after `cs_n` rises. A bad opcode check makes `so_oe` rise on a foreign opcode.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;
  localparam int STAT_W = 8;
  localparam int PTR_W  = $clog2(STAT_W);

  typedef enum logic [1:0] {
    PH_OPCODE = 2'd0,
    PH_SEND   = 2'd1,
    PH_SKIP   = 2'd2
  } phase_e;
endpackage

// File: rtl/flash_stat_edge.sv
module flash_stat_edge (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  output logic rise,
  output logic fall
);
  logic sck_q;

  always_ff @(posedge clk) begin
    if (rst) sck_q <= 1'b0;
    else     sck_q <= sck;
  end

  assign rise = sck & ~sck_q;
  assign fall = ~sck & sck_q;
endmodule

// File: rtl/flash_stat_byte.sv
module flash_stat_byte
  import flash_stat_pkg::*;
#(
  parameter int         N_SRC   = 8,
  parameter logic [3:0] DENSITY = 4'b0111
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  busy_src,
  input  logic              cmp_done,
  input  logic              cmp_mismatch,
  output logic [STAT_W-1:0] stat
);
  logic cmp_flag;

  always_ff @(posedge clk) begin
    if (rst)           cmp_flag <= 1'b0;
    else if (cmp_done) cmp_flag <= cmp_mismatch;
  end

  assign stat = {~(|busy_src), cmp_flag, DENSITY, 2'b00};

  // R2: compare outcome is captured on completion
  assert_cmp_capture_R2: assert property (@(posedge clk) disable iff (rst)
    cmp_done |=> (cmp_flag == $past(cmp_mismatch)));

  // R3: flag is held between compares
  assert_cmp_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    !cmp_done |=> $stable(cmp_flag));
endmodule

// File: rtl/flash_stat_shift.sv
module flash_stat_shift
  import flash_stat_pkg::*;
#(
  parameter int               OPC_W  = 8,
  parameter logic [OPC_W-1:0] OPCODE = 8'hD7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              si,
  input  logic              rise,
  input  logic              fall,
  input  logic [STAT_W-1:0] stat,
  output logic              so,
  output logic              so_oe
);
  localparam int CNT_W = $clog2(OPC_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(OPC_W - 1);
  localparam logic [PTR_W-1:0] TOP_BIT  = PTR_W'(STAT_W - 1);

  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic [OPC_W-2:0] sr;
  logic [PTR_W-1:0] ptr;
  logic [PTR_W-1:0] shown;
  logic             launched;
  logic             so_q;
  logic             oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_OPCODE;
      cnt      <= '0;
      sr       <= '0;
      ptr      <= TOP_BIT;
      shown    <= TOP_BIT;
      launched <= 1'b0;
      so_q     <= 1'b0;
      oe_q     <= 1'b0;
    end else if (cs_n) begin
      phase    <= PH_OPCODE;
      cnt      <= '0;
      ptr      <= TOP_BIT;
      shown    <= TOP_BIT;
      launched <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      unique case (phase)
        PH_OPCODE: begin
          if (rise) begin
            sr  <= {sr[OPC_W-3:0], si};
            cnt <= cnt + 1'b1;
            if (cnt == LAST_BIT)
              phase <= ({sr, si} == OPCODE) ? PH_SEND : PH_SKIP;
          end
        end
        PH_SEND: begin
          if (fall) begin
            so_q     <= stat[ptr];
            shown    <= ptr;
            ptr      <= ptr - 1'b1;
            launched <= 1'b1;
            oe_q     <= 1'b1;
          end else if (launched && shown == TOP_BIT) begin
            so_q <= stat[STAT_W-1];
          end
        end
        default: ;
      endcase
    end
  end

  assign so    = so_q;
  assign so_oe = oe_q;

  // R9: output released one clock after deselect
  assert_release_on_deselect_R9: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> !so_oe);

  // R10: a foreign opcode never enables the output
  assert_skip_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SKIP) |-> !so_oe);

  // R5: the two low bits leave as zero
  assert_low_bits_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (so_oe && shown < PTR_W'(2)) |-> !so);

  // R7: while parked on the ready bit, output follows live readiness
  assert_live_ready_R7: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && so_oe && shown == TOP_BIT && !fall) |=> (so == $past(stat[STAT_W-1])));
endmodule

// File: rtl/flash_stat_out.sv
module flash_stat_out
  import flash_stat_pkg::*;
#(
  parameter int               N_SRC   = 8,
  parameter int               OPC_W   = 8,
  parameter logic [OPC_W-1:0] OPCODE  = 8'hD7,
  parameter logic [3:0]       DENSITY = 4'b0111
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             sck,
  input  logic             si,
  input  logic [N_SRC-1:0] busy_src,
  input  logic             cmp_done,
  input  logic             cmp_mismatch,
  output logic             so,
  output logic             so_oe
);
  logic              rise;
  logic              fall;
  logic [STAT_W-1:0] stat;

  flash_stat_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .sck  (sck),
    .rise (rise),
    .fall (fall)
  );

  flash_stat_byte #(
    .N_SRC   (N_SRC),
    .DENSITY (DENSITY)
  ) u_byte (
    .clk          (clk),
    .rst          (rst),
    .busy_src     (busy_src),
    .cmp_done     (cmp_done),
    .cmp_mismatch (cmp_mismatch),
    .stat         (stat)
  );

  flash_stat_shift #(
    .OPC_W  (OPC_W),
    .OPCODE (OPCODE)
  ) u_shift (
    .clk   (clk),
    .rst   (rst),
    .cs_n  (cs_n),
    .si    (si),
    .rise  (rise),
    .fall  (fall),
    .stat  (stat),
    .so    (so),
    .so_oe (so_oe)
  );
endmodule

// File: tb/flash_stat_out_bench.sv
module flash_stat_out_bench;
  localparam logic [7:0] OPC  = 8'hD7;
  localparam logic [3:0] DENS = 4'b0111;

  // vector: {busy_src[7:0], do_cmp, mismatch}
  localparam int NV = 8;
  localparam logic [9:0] VEC [NV] = '{
    {8'h00, 1'b0, 1'b0},
    {8'h01, 1'b1, 1'b1},
    {8'h80, 1'b0, 1'b0},
    {8'h00, 1'b1, 1'b0},
    {8'h24, 1'b1, 1'b1},
    {8'h00, 1'b0, 1'b0},
    {8'h10, 1'b1, 1'b0},
    {8'h02, 1'b0, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1;
  logic       sck = 1'b0;
  logic       si = 1'b0;
  logic [7:0] busy_src = 8'h00;
  logic       cmp_done = 1'b0;
  logic       cmp_mismatch = 1'b0;
  logic       so;
  logic       so_oe;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic model_cmp = 1'b0;

  always #4 clk = ~clk;

  flash_stat_out u_flash_stat_out (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si),
    .busy_src(busy_src), .cmp_done(cmp_done), .cmp_mismatch(cmp_mismatch),
    .so(so), .so_oe(so_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte();
    return {~(|busy_src), model_cmp, DENS, 2'b00};
  endfunction

  task automatic clk_bit(input logic b, output logic o, output logic e);
    @(negedge clk) si = b;
    @(negedge clk) sck = 1'b1;
    @(negedge clk);
    @(negedge clk) sck = 1'b0;
    @(negedge clk);
    o = so;
    e = so_oe;
  endtask

  task automatic select();
    @(negedge clk) cs_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic deselect(input string req);
    @(negedge clk) cs_n = 1'b1;
    @(negedge clk);
    check(req, {7'd0, so_oe}, 8'd0);
  endtask

  // shifts opcode; returns bit 7 and whether oe was seen during opcode
  task automatic send_op(input logic [7:0] op, output logic b7, output logic e7,
                         output logic early_oe);
    logic o, e;
    early_oe = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(op[i], o, e);
      if (i > 0) early_oe = early_oe | e;
    end
    b7 = o;
    e7 = e;
  endtask

  task automatic rest_bits(inout logic [7:0] byt, output logic all_oe);
    logic o, e;
    all_oe = 1'b1;
    for (int k = 6; k >= 0; k--) begin
      clk_bit(1'b0, o, e);
      byt[k] = o;
      all_oe = all_oe & e;
    end
  endtask

  task automatic pulse_cmp(input logic mism);
    @(negedge clk) begin cmp_done = 1'b1; cmp_mismatch = mism; end
    @(negedge clk) begin cmp_done = 1'b0; cmp_mismatch = ~mism; end
    model_cmp = mism;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] byt;
    logic b7, e7, early, all_oe, o, e;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11 so_oe after reset", {7'd0, so_oe}, 8'd0);

    // reset value of the compare flag, seen through a status read
    select();
    send_op(OPC, b7, e7, early);
    byt[7] = b7;
    rest_bits(byt, all_oe);
    check("R11 byte after reset", byt, 8'h9C);
    check("R9 oe low during opcode", {7'd0, early}, 8'd0);
    deselect("R9 released after read");

    // table walk: R1 R2 R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      busy_src = VEC[v][9:2];
      if (VEC[v][1]) pulse_cmp(VEC[v][0]);
      else begin
        @(negedge clk) cmp_mismatch = VEC[v][0];
      end
      select();
      send_op(OPC, b7, e7, early);
      byt[7] = b7;
      rest_bits(byt, all_oe);
      check($sformatf("R1 R2 R3 R4 R5 R6 vec%0d", v), byt, exp_byte());
      check($sformatf("R6 oe during byte vec%0d", v), {6'd0, e7, all_oe}, 8'h03);
      deselect("R9 released after vector");
    end

    // R1: each single source forces busy
    for (int s = 0; s < 8; s++) begin
      busy_src = 8'h01 << s;
      select();
      send_op(OPC, b7, e7, early);
      check($sformatf("R1 source %0d", s), {7'd0, b7}, 8'd0);
      deselect("R9 after source read");
    end

    // R7 live polling, then R8 resume and repeat
    busy_src = 8'h08;
    pulse_cmp(1'b1);
    select();
    send_op(OPC, b7, e7, early);
    check("R7 busy shown", {7'd0, b7}, 8'd0);
    repeat (6) @(negedge clk);
    check("R7 parked busy holds", {6'd0, so_oe, so}, 8'h02);
    busy_src = 8'h00;
    @(negedge clk);
    check("R7 ready rises one clock later", {6'd0, so_oe, so}, 8'h03);
    busy_src = 8'h40;
    @(negedge clk);
    check("R7 follows back to busy", {7'd0, so}, 8'd0);
    busy_src = 8'h00;
    @(negedge clk);
    byt = 8'h00;
    byt[7] = so;
    rest_bits(byt, all_oe);
    check("R8 resume bits 6..0", byt, exp_byte());
    clk_bit(1'b0, o, e);
    check("R8 repeat from bit 7", {6'd0, e, o}, 8'h03);
    clk_bit(1'b0, o, e);
    check("R8 repeat bit 6", {7'd0, o}, {7'd0, model_cmp});

    // R9: deselect mid-byte
    @(negedge clk) cs_n = 1'b1;
    @(negedge clk);
    check("R9 release mid-byte", {7'd0, so_oe}, 8'd0);
    repeat (2) @(negedge clk);

    // R10: foreign opcode
    select();
    send_op(8'h05, b7, e7, early);
    rest_bits(byt, all_oe);
    check("R10 no output on foreign opcode", {6'd0, e7, early}, 8'd0);
    clk_bit(1'b0, o, e);
    check("R10 stays released", {7'd0, e}, 8'd0);
    deselect("R9 after foreign opcode");

    // R3: mismatch input toggles without completion
    pulse_cmp(1'b0);
    repeat (3) begin
      @(negedge clk) cmp_mismatch = ~cmp_mismatch;
    end
    select();
    send_op(OPC, b7, e7, early);
    byt[7] = b7;
    rest_bits(byt, all_oe);
    check("R3 flag unchanged without done", byt, exp_byte());
    deselect("R9 final");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule